// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point words and returns their product in the same word format. A word holds a sign in its top bit, then a biased exponent field, then a fraction field. The widths are parameters and default to 8 exponent bits and 23 fraction bits, with a bias of 2^(EXP_W-1)-1, which is 127 by default. A normalized value has an implied leading one above its fraction. The block puts that one back before it multiplies the significands.

The datapath has two register stages, and a new operand pair may enter on every cycle. The first stage classifies both operands from their reserved exponent patterns. In the same stage it forms the full significand product and the exponent sum less one bias. The second stage shifts right by at most one place to normalize, truncates the fraction (round toward zero), detects overflow and underflow, and packs the result word.

An exponent field of all zeros is read as zero, whatever the fraction, so subnormal inputs are flushed to zero. The only status outputs are two flags, one for overflow and one for underflow.

Top module: `fp_mul`

## Requirements
- R1: For every result that is not a NaN, the result sign (bit W-1) is the XOR of the two operand signs.
- R2: When both operands are normalized (exponent field from 1 to all-ones minus 1), the significand product (with the leading ones restored) is shifted right once if its top bit is set. The exponent is then sum-of-exponents minus bias, plus one if that shift was taken. The fraction is the next FRAC_W product bits, truncated, and the result is packed as sign, exponent and fraction.
- R3: If the exponent from R2 is above all-ones minus 1, the result is a signed infinity (exponent field all ones, fraction 0) and `ovf` is 1.
- R4: If the exponent from R2 is below 1, the result is a signed zero (exponent and fraction 0) and `unf` is 1.
- R5: An operand with an all-zero exponent field counts as zero, whatever its fraction. Zero times a zero or normalized operand gives a signed zero.
- R6: Infinity (exponent all ones, fraction 0) times infinity or a normalized operand gives a signed infinity.
- R7: A NaN operand (exponent all ones, fraction nonzero), or infinity times zero, gives the quiet NaN word. That word has sign 0, an all-ones exponent, and a fraction with only its top bit set.
- R8: Reset clears `out_valid`, `result`, `ovf` and `unf`. A pair accepted with `in_valid` high on one rising edge appears with `out_valid` high after the second rising edge that follows.
- R9: `ovf` and `unf` are never both 1. Both are 0 for the special-value cases R5, R6 and R7 and for in-range products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present on a and b |
| a | input | 1+EXP_W+FRAC_W | First operand word |
| b | input | 1+EXP_W+FRAC_W | Second operand word |
| out_valid | output | 1 | result, ovf and unf hold a product |
| result | output | 1+EXP_W+FRAC_W | Product word |
| ovf | output | 1 | Product exponent overflowed to infinity |
| unf | output | 1 | Product exponent underflowed to zero |

## Verification
The assertions assume that `in_valid` and the operand words are driven to known values on every cycle after reset. They also assume that reset stays asserted for at least one edge, so that the two-cycle lookback on the operand signs starts from defined data. The bench drives every input at the falling edge and holds `in_valid` low with zero operands during reset.

In a reduced configuration (4 exponent bits, 3 fraction bits), the bench sweeps every pair of 8-bit words. That sweep reaches every reserved pattern, every subnormal and both exponent extremes. At the default width it runs directed special values, then random normalized operands whose exponents include values near both range limits.

// File: rtl/fp_mul.sv
module fp_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     a,
  input  logic [EXP_W+FRAC_W:0]     b,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      ovf,
  output logic                      unf
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int MW   = FRAC_W + 1;
  localparam int PW   = 2 * MW;
  localparam int SW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;

  localparam logic [1:0] K_NUM  = 2'd0;
  localparam logic [1:0] K_ZERO = 2'd1;
  localparam logic [1:0] K_INF  = 2'd2;
  localparam logic [1:0] K_NAN  = 2'd3;

  localparam logic [EXP_W-1:0]  E_ONES = '1;
  localparam logic [FRAC_W-1:0] F_QNAN = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0]      QNAN   = {1'b0, E_ONES, F_QNAN};

  // operand decode
  wire [EXP_W-1:0]  ea = a[W-2:FRAC_W];
  wire [EXP_W-1:0]  eb = b[W-2:FRAC_W];
  wire [FRAC_W-1:0] fa = a[FRAC_W-1:0];
  wire [FRAC_W-1:0] fb = b[FRAC_W-1:0];

  wire a_zero = (ea == '0);
  wire b_zero = (eb == '0);
  wire a_inf  = (ea == E_ONES) && (fa == '0);
  wire b_inf  = (eb == E_ONES) && (fb == '0);
  wire a_nan  = (ea == E_ONES) && (fa != '0);
  wire b_nan  = (eb == E_ONES) && (fb != '0);

  logic [1:0] kind_d;
  always_comb begin
    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
      kind_d = K_NAN;
    else if (a_inf || b_inf)
      kind_d = K_INF;
    else if (a_zero || b_zero)
      kind_d = K_ZERO;
    else
      kind_d = K_NUM;
  end

  wire [SW-1:0] esum_d = SW'(ea) + SW'(eb) - SW'(BIAS);
  wire [PW-1:0] prod_d = PW'({1'b1, fa}) * PW'({1'b1, fb});

  // stage 1
  logic          v1, s1;
  logic [1:0]    k1;
  logic [SW-1:0] e1;
  logic [PW-1:0] p1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      s1 <= 1'b0;
      k1 <= K_ZERO;
      e1 <= '0;
      p1 <= '0;
    end else begin
      v1 <= in_valid;
      s1 <= a[W-1] ^ b[W-1];
      k1 <= kind_d;
      e1 <= esum_d;
      p1 <= prod_d;
    end
  end

  // normalize and pack
  wire              top   = p1[PW-1];
  wire [SW-1:0]     enorm = e1 + SW'(top);
  wire [FRAC_W-1:0] fnorm = top ? p1[PW-2 -: FRAC_W] : p1[PW-3 -: FRAC_W];
  wire              big   = $signed(enorm) > $signed(SW'(EMAX - 1));
  wire              tiny  = $signed(enorm) < $signed(SW'(1));

  logic [W-1:0] res_d;
  logic         ovf_d, unf_d;
  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    case (k1)
      K_NAN:  res_d = QNAN;
      K_INF:  res_d = {s1, E_ONES, {FRAC_W{1'b0}}};
      K_ZERO: res_d = {s1, {(W-1){1'b0}}};
      default: begin
        if (big) begin
          res_d = {s1, E_ONES, {FRAC_W{1'b0}}};
          ovf_d = 1'b1;
        end else if (tiny) begin
          res_d = {s1, {(W-1){1'b0}}};
          unf_d = 1'b1;
        end else begin
          res_d = {s1, enorm[EXP_W-1:0], fnorm};
        end
      end
    endcase
  end

  // stage 2
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= v1;
      result    <= res_d;
      ovf       <= ovf_d;
      unf       <= unf_d;
    end
  end
endmodule

module fp_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] a,
  input logic [EXP_W+FRAC_W:0] b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  ovf,
  input logic                  unf
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0]  E_ONES = '1;
  localparam logic [W-1:0] QNAN = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  wire res_nan = (result[W-2:FRAC_W] == E_ONES) && (result[FRAC_W-1:0] != '0);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && out_valid && !res_nan) |->
      (result[W-1] == $past(a[W-1] ^ b[W-1], 2)));

  assert_ovf_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result[W-2:FRAC_W] == E_ONES && result[FRAC_W-1:0] == '0));

  assert_unf_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (result[W-2:0] == '0));

  assert_qnan_canon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_nan |-> (result == QNAN && !ovf && !unf));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf, unf}) <= 1);
endmodule

bind fp_mul fp_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
);

// File: tb/sim_fp_mul.sv
module sim_fp_mul;
  localparam int SE = 4, SF = 3, SW = 1 + SE + SF;
  localparam int DE = 8, DF = 23, DW = 1 + DE + DF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          iv0 = 1'b0, ov0, of0, uf0;
  logic [SW-1:0] a0 = '0, b0 = '0, r0;
  logic          iv1 = 1'b0, ov1, of1, uf1;
  logic [DW-1:0] a1 = '0, b1 = '0, r1;

  fp_mul #(.EXP_W(SE), .FRAC_W(SF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv0), .a(a0), .b(b0),
    .out_valid(ov0), .result(r0), .ovf(of0), .unf(uf0));
  fp_mul #(.EXP_W(DE), .FRAC_W(DF)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv1), .a(a1), .b(b1),
    .out_valid(ov1), .result(r1), .ovf(of1), .unf(uf1));

  typedef struct {
    longint a, b, r;
    bit     ov, un;
    int     tag;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  function automatic string tname(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // truncating reference model for any field widths
  function automatic exp_t ref_mul(int E, int F, longint a, longint b);
    exp_t x;
    longint emax = (longint'(1) << E) - 1;
    longint fmask = (longint'(1) << F) - 1;
    longint bias = (longint'(1) << (E - 1)) - 1;
    longint ea = (a >> F) & emax, eb = (b >> F) & emax;
    longint fa = a & fmask, fb = b & fmask;
    longint s = ((a ^ b) >> (E + F)) & 1;
    longint p, e, fr;
    bit an = (ea == emax) && (fa != 0), bn = (eb == emax) && (fb != 0);
    bit ai = (ea == emax) && (fa == 0), bi = (eb == emax) && (fb == 0);
    bit az = (ea == 0), bz = (eb == 0);
    x.a = a; x.b = b; x.ov = 0; x.un = 0;
    if (an || bn || (ai && bz) || (bi && az)) begin
      x.tag = 7; x.r = (emax << F) | (longint'(1) << (F - 1));
    end else if (ai || bi) begin
      x.tag = 6; x.r = (s << (E + F)) | (emax << F);
    end else if (az || bz) begin
      x.tag = 5; x.r = s << (E + F);
    end else begin
      p = (fa | (longint'(1) << F)) * (fb | (longint'(1) << F));
      e = ea + eb - bias;
      if (((p >> (2 * F + 1)) & 1) != 0) begin
        e = e + 1; fr = (p >> (F + 1)) & fmask;
      end else fr = (p >> F) & fmask;
      if (e > emax - 1) begin
        x.tag = 3; x.ov = 1; x.r = (s << (E + F)) | (emax << F);
      end else if (e < 1) begin
        x.tag = 4; x.un = 1; x.r = s << (E + F);
      end else begin
        x.tag = 2; x.r = (s << (E + F)) | (e << F) | fr;
      end
    end
    return x;
  endfunction

  task automatic compare(exp_t x, longint r, bit ov, bit un, int E, int F);
    longint sgn = longint'(1) << (E + F);
    n_tests++;
    if (r != x.r) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h result=%h expected=%h", tname(x.tag), x.a, x.b, r, x.r);
    end
    n_tests++;
    if (ov != x.ov || un != x.un) begin
      n_fail++;
      $display("FAIL R9 a=%h b=%h flags ovf/unf=%0d%0d expected=%0d%0d", x.a, x.b, ov, un, x.ov, x.un);
    end
    if (x.tag != 7) begin
      n_tests++;
      if ((r & sgn) != (x.r & sgn)) begin
        n_fail++;
        $display("FAIL R1 a=%h b=%h sign=%0d expected=%0d", x.a, x.b, (r & sgn) != 0, (x.r & sgn) != 0);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ov0) begin
      if (q0.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8 u0 out_valid=1 expected=0 (nothing issued)");
      end else compare(q0.pop_front(), longint'(r0), of0, uf0, SE, SF);
    end
    if (rst_n && ov1) begin
      if (q1.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8 u1 out_valid=1 expected=0 (nothing issued)");
      end else compare(q1.pop_front(), longint'(r1), of1, uf1, DE, DF);
    end
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive0();
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        iv0 = 1'b1; a0 = SW'(i); b0 = SW'(j);
        q0.push_back(ref_mul(SE, SF, longint'(i), longint'(j)));
      end
    end
    @(negedge clk);
    iv0 = 1'b0;
  endtask

  task automatic put1(logic [DW-1:0] x, logic [DW-1:0] y);
    @(negedge clk);
    iv1 = 1'b1; a1 = x; b1 = y;
    q1.push_back(ref_mul(DE, DF, longint'(x), longint'(y)));
  endtask

  task automatic drive1();
    logic [DW-1:0] dir [16] = '{
      32'h3FC00000, 32'h40000000,   // 1.5 * 2.0 (R2)
      32'h40400000, 32'h40A00000,   // 3 * 5 (R2)
      32'h7F000000, 32'h7F000000,   // overflow (R3)
      32'h00800000, 32'h00800000,   // underflow (R4)
      32'h00000001, 32'h3F800000,   // subnormal flushed (R5)
      32'h7F800000, 32'h00000000,   // inf * 0 (R7)
      32'hFF800000, 32'h40000000,   // -inf * 2 (R6)
      32'h7FA00001, 32'h3F800000    // NaN in (R7)
    };
    // latency check (R8)
    put1(32'h3F800000, 32'hBF800000);
    @(negedge clk);
    iv1 = 1'b0;
    chk(ov1 == 1'b0, "R8 one edge after issue", longint'(ov1), 0);
    @(negedge clk);
    chk(ov1 == 1'b1, "R8 two edges after issue", longint'(ov1), 1);
    for (int k = 0; k < 8; k++) put1(dir[2*k], dir[2*k+1]);
    put1(32'h80000000, 32'h40400000);  // -0 * 3 (R5)
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ex, ey;
      ex = 8'($urandom_range(1, 254));
      ey = (k % 3 == 0) ? 8'($urandom_range(1, 40)) :
           (k % 3 == 1) ? 8'($urandom_range(200, 254)) : 8'($urandom_range(1, 254));
      put1({1'($urandom), ex, 23'($urandom)}, {1'($urandom), ey, 23'($urandom)});
    end
    @(negedge clk);
    iv1 = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ov0 == 0 && r0 == 0 && of0 == 0 && uf0 == 0, "R8 reset u0", longint'(r0), 0);
    chk(ov1 == 0 && r1 == 0 && of1 == 0 && uf1 == 0, "R8 reset u1", longint'(r1), 0);
    rst_n = 1'b1;
    fork
      drive0();
      drive1();
    join
    repeat (4) @(negedge clk);
    chk(q0.size() == 0, "R8 u0 all results returned", q0.size(), 0);
    chk(q1.size() == 0, "R8 u1 all results returned", q1.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule